// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block gives software a word-wide bank of pins through a small register bus. Each pin can be driven or read. Output data, direction, an input-path bypass and the pull configuration live in 32-bit registers, one word every four bytes. The output data word can be rewritten whole. It can also be changed bit by bit through a write-one-to-set port and a write-one-to-clear port, so one pin can be moved without a read-modify-write. The pad side receives the output value, the per-pin output enable and the two pull controls.

Pin inputs pass through a two-stage synchronizer before software reads them. A per-pin bypass bit selects the raw pad value instead, for pins already known to be synchronous to the bus clock. The bus has no handshake. A write takes effect at the clock edge on which `bus_we` is sampled high. Read data is a combinational function of `bus_addr` and the current register state, so it is valid in the same cycle as the address, and it is never stalled. Interrupt detection and debouncing are not part of this block.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register holds zero until it is written. So `pad_out`, `pad_oe`, `pad_pull_en` and `pad_pull_sel` are all zero and every pin is an input.
- R2: A write to offset 0x00 replaces the whole output data word. The new value appears on `pad_out` after that clock edge.
- R3: A write to offset 0x10 sets each output data bit whose write-data bit is 1. All other bits are left unchanged.
- R4: A write to offset 0x14 clears each output data bit whose write-data bit is 1. All other bits are left unchanged.
- R5: The direction register at offset 0x08 drives `pad_oe`. A bit of 1 makes the pin an output and a bit of 0 makes it an input. `pad_oe` changes only on a write to 0x08.
- R6: The pull-enable register at offset 0x18 drives `pad_pull_en`, and the pull-type register at offset 0x1C drives `pad_pull_sel`. Each changes only when its own offset is written.
- R7: A read of offset 0x04 returns, for each pin whose bypass bit is 0, the `pad_in` value sampled two clock edges earlier.
- R8: The bypass register sits at offset 0x0C. For each pin whose bypass bit is 1, a read of 0x04 returns the current `pad_in` value in the same cycle.
- R9: Reads return zero at these addresses: offsets 0x10 and 0x14, any address whose low two bits are not zero, and any offset of 0x20 or above. Writes to those addresses, and writes to 0x04, change no register.
- R10: Reads of offsets 0x00, 0x08, 0x0C, 0x18 and 0x1C return the value held in that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | PINS (32) | Write data |
| bus_rdata | output | PINS (32) | Read data for `bus_addr`, same cycle |
| pad_in | input | PINS (32) | Pin levels from the pads, asynchronous |
| pad_out | output | PINS (32) | Output data driven to the pads |
| pad_oe | output | PINS (32) | Per-pin output enable |
| pad_pull_en | output | PINS (32) | Per-pin pull enable |
| pad_pull_sel | output | PINS (32) | Per-pin pull type |

## Verification
The bound checker watches several rules on every cycle. It checks the effect of a set, clear or direct write on `pad_out` at the next edge. It checks that `pad_oe` and both pull outputs hold unless their own offset is written, and that unmapped addresses read as zero. The two-edge latency of the synchronized input path and its interaction with the bypass bits can only be seen in bench scenarios, where pad values change around reads. The same holds for the proof that writes to read-only and unmapped addresses leave every register intact.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register word indices; the byte offset of each is index * 4.
  typedef enum logic [2:0] {
    SEL_DOUT  = 3'd0,
    SEL_DIN   = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_BYP   = 3'd3,
    SEL_SET   = 3'd4,
    SEL_CLR   = 3'd5,
    SEL_PEN   = 3'd6,
    SEL_PTYPE = 3'd7
  } reg_sel_e;

  localparam int OFF_DOUT  = 'h00;
  localparam int OFF_DIN   = 'h04;
  localparam int OFF_DIR   = 'h08;
  localparam int OFF_BYP   = 'h0C;
  localparam int OFF_SET   = 'h10;
  localparam int OFF_CLR   = 'h14;
  localparam int OFF_PEN   = 'h18;
  localparam int OFF_PTYPE = 'h1C;

  localparam int SEL_W  = 3;
  localparam int BYTE_W = 2;

endpackage

// File: rtl/gpio_port_dec.sv
module gpio_port_dec
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              hit
);
  localparam int LOW_W = SEL_W + BYTE_W;

  logic upper_zero;

  generate
    if (ADDR_W > LOW_W) begin : g_upper
      assign upper_zero = ~|addr[ADDR_W-1:LOW_W];
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign sel = reg_sel_e'(addr[LOW_W-1:BYTE_W]);
  assign hit = upper_zero && (addr[BYTE_W-1:0] == '0);

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] byp_q,
  output logic [W-1:0] pen_q,
  output logic [W-1:0] ptype_q
);
  logic [W-1:0] dout_d;

  always_comb begin
    dout_d = dout_q;
    if (wr) begin
      case (sel)
        SEL_DOUT: dout_d = wdata;
        SEL_SET:  dout_d = dout_q | wdata;
        SEL_CLR:  dout_d = dout_q & ~wdata;
        default:  dout_d = dout_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      byp_q   <= '0;
      pen_q   <= '0;
      ptype_q <= '0;
    end else begin
      dout_q <= dout_d;
      if (wr && sel == SEL_DIR)   dir_q   <= wdata;
      if (wr && sel == SEL_BYP)   byp_q   <= wdata;
      if (wr && sel == SEL_PEN)   pen_q   <= wdata;
      if (wr && sel == SEL_PTYPE) ptype_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         hit,
  input  reg_sel_e     sel,
  input  logic [W-1:0] dout_q,
  input  logic [W-1:0] din_view,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] byp_q,
  input  logic [W-1:0] pen_q,
  input  logic [W-1:0] ptype_q,
  output logic [W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (hit) begin
      case (sel)
        SEL_DOUT:  rdata = dout_q;
        SEL_DIN:   rdata = din_view;
        SEL_DIR:   rdata = dir_q;
        SEL_BYP:   rdata = byp_q;
        SEL_PEN:   rdata = pen_q;
        SEL_PTYPE: rdata = ptype_q;
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_pull_en,
  output logic [PINS-1:0]   pad_pull_sel
);
  reg_sel_e        sel;
  logic            hit;
  logic [PINS-1:0] dout_q, dir_q, byp_q, pen_q, ptype_q;
  logic [PINS-1:0] pin_sync, din_view;

  gpio_port_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .hit  (hit)
  );

  gpio_port_regs #(.W(PINS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_we && hit),
    .sel     (sel),
    .wdata   (bus_wdata),
    .dout_q  (dout_q),
    .dir_q   (dir_q),
    .byp_q   (byp_q),
    .pen_q   (pen_q),
    .ptype_q (ptype_q)
  );

  gpio_port_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  assign din_view = (byp_q & pad_in) | (~byp_q & pin_sync);

  gpio_port_rdmux #(.W(PINS)) u_rdmux (
    .hit      (hit),
    .sel      (sel),
    .dout_q   (dout_q),
    .din_view (din_view),
    .dir_q    (dir_q),
    .byp_q    (byp_q),
    .pen_q    (pen_q),
    .ptype_q  (ptype_q),
    .rdata    (bus_rdata)
  );

  assign pad_out      = dout_q;
  assign pad_oe       = dir_q;
  assign pad_pull_en  = pen_q;
  assign pad_pull_sel = ptype_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pad_in,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pad_pull_en,
  input logic [PINS-1:0]   pad_pull_sel
);
  logic mapped;
  assign mapped = (int'(bus_addr) == OFF_DOUT) || (int'(bus_addr) == OFF_DIN) ||
                  (int'(bus_addr) == OFF_DIR)  || (int'(bus_addr) == OFF_BYP) ||
                  (int'(bus_addr) == OFF_PEN)  || (int'(bus_addr) == OFF_PTYPE);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert ((pad_out | pad_oe | pad_pull_en | pad_pull_sel) == '0); // R1
    end
  end

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr) == OFF_DOUT) |=> pad_out == $past(bus_wdata)); // R2

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr) == OFF_SET) |=> pad_out == ($past(pad_out) | $past(bus_wdata))); // R3

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && int'(bus_addr) == OFF_CLR) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata))); // R4

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && int'(bus_addr) == OFF_DIR) |=> $stable(pad_oe)); // R5

  AST_PULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (int'(bus_addr) == OFF_PEN || int'(bus_addr) == OFF_PTYPE))
      |=> ($stable(pad_pull_en) && $stable(pad_pull_sel))); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0); // R9

endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pull_en, pad_pull_sel;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [31:0] m_out = '0, m_dir = '0, m_byp = '0, m_pen = '0, m_ptype = '0;
  logic [31:0] m_s1 = '0, m_s2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .pad_pull_en  (pad_pull_en),
    .pad_pull_sel (pad_pull_sel)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] p);
    case (a)
      8'h00: return m_out;
      8'h04: return (m_byp & p) | (~m_byp & m_s2);
      8'h08: return m_dir;
      8'h0C: return m_byp;
      8'h18: return m_pen;
      8'h1C: return m_ptype;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h04: return "R7/R8";
      8'h00, 8'h08, 8'h0C, 8'h18, 8'h1C: return "R10";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check read and pads before the edge, update model after it.
  task automatic step(input logic [7:0] a, input logic we, input logic [31:0] d,
                      input logic [31:0] p, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d; pad_in = p;
    #1;
    check({tag, " read ", req_of(a)}, {96'h0, bus_rdata}, {96'h0, exp_read(a, p)});
    check({tag, " pads R2 R3 R4 R5 R6"}, {pad_out, pad_oe, pad_pull_en, pad_pull_sel},
          {m_out, m_dir, m_pen, m_ptype});
    @(posedge clk);
    m_s2 = m_s1;
    m_s1 = p;
    if (we) begin
      case (a)
        8'h00: m_out = d;
        8'h08: m_dir = d;
        8'h0C: m_byp = d;
        8'h10: m_out = m_out | d;
        8'h14: m_out = m_out & ~d;
        8'h18: m_pen = d;
        8'h1C: m_ptype = d;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [12];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
              8'h20, 8'h02, 8'hFC, 8'h11};
    void'($urandom(32'd20240611));
    pad_in = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk);
    #1;
    // R1: all pad controls zero while in reset
    check("R1 reset", {pad_out, pad_oe, pad_pull_en, pad_pull_sel}, 128'h0);
    @(negedge clk);
    pad_in = '0;
    rst_n = 1'b1;

    // R1: registers read zero after release
    step(8'h00, 0, 0, 0, "R1");
    step(8'h08, 0, 0, 0, "R1");
    step(8'h1C, 0, 0, 0, "R1");

    // R2 direct write, R3 set, R4 clear
    step(8'h00, 1, 32'hA5A5_0F0F, 0, "R2");
    step(8'h10, 1, 32'h0000_F0F0, 0, "R3");
    step(8'h14, 1, 32'hA000_0001, 0, "R4");
    step(8'h10, 1, 32'h0, 0, "R3 zero-set");
    step(8'h14, 1, 32'h0, 0, "R4 zero-clear");
    step(8'h00, 0, 0, 0, "R10");

    // R5, R6
    step(8'h08, 1, 32'hFFFF_0000, 0, "R5");
    step(8'h18, 1, 32'h1234_5678, 0, "R6");
    step(8'h1C, 1, 32'h8765_4321, 0, "R6");
    step(8'h18, 0, 0, 0, "R6");

    // R9: writes to read-only and unmapped addresses
    step(8'h04, 1, 32'hFFFF_FFFF, 0, "R9");
    step(8'h20, 1, 32'hFFFF_FFFF, 0, "R9");
    step(8'h02, 1, 32'hFFFF_FFFF, 0, "R9");
    step(8'h0A, 1, 32'hFFFF_FFFF, 0, "R9");
    step(8'h10, 0, 0, 0, "R9 set reads zero");
    step(8'h14, 0, 0, 0, "R9 clr reads zero");

    // R7: synchronized input latency
    step(8'h04, 0, 0, 32'h5555_AAAA, "R7");
    step(8'h04, 0, 0, 32'h5555_AAAA, "R7");
    step(8'h04, 0, 0, 32'h0F0F_0F0F, "R7");
    step(8'h04, 0, 0, 32'h0F0F_0F0F, "R7");

    // R8: bypass half the pins
    step(8'h0C, 1, 32'h0000_FFFF, 32'h0F0F_0F0F, "R8");
    step(8'h04, 0, 0, 32'hFFFF_FFFF, "R8");
    step(8'h04, 0, 0, 32'h0000_0000, "R8");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      a = addrs[$urandom_range(11, 0)];
      step(a, 1'($urandom_range(1, 0)), $urandom, $urandom, "rand");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule